// File: doc/BRIEF.md
# Host SRAM Pointer Access Port

This block gives a host bus a register window onto a byte-addressed packet SRAM. The receive side of the SRAM is read through a read pointer and the transmit side is written through a write pointer. Each pointer is a 16-bit value that the host reaches as two byte registers. Data moves through command registers. A host read of a command register returns SRAM data at the read pointer, either leaving the pointer alone (peek) or stepping it past the data (pop). A host write of a command register stores data at the write pointer, with or without a step. The step and the number of bytes moved follow the bus width mode: 8, 16 or 32 bits. Wider data is assembled little-endian from consecutive bytes.

The SRAM returns data one cycle after it is addressed, so the port holds `host_ready` low for the first cycle of a command read. A receive-region mode input, driven by the host's interrupt mask control, does two things. On its rising edge it moves the read pointer high byte to 0Ch. While it stays high, a read pointer that steps past 3FFFh comes back into the region at 0C00h.

Top module: `hsp_port`

## Requirements
- R1: After reset the read pointer (offsets F4h low, F5h high) and the write pointer (offsets FAh low, FBh high) all read 00h.
- R2: `bus_mode` selects the width: 00 is 8-bit (step 1), 01 is 16-bit (step 2), 10 is 32-bit (step 4), and 11 behaves as 8-bit.
- R3: A read of offset F0h returns the data at the read pointer and leaves the read pointer unchanged.
- R4: A read of offset F2h returns the data at the read pointer and then advances the read pointer by the step of the current mode.
- R5: A command read (F0h, F2h) raises `host_ready` in the cycle after the request, not in the request cycle. A pointer register read, or a read of any other offset, is ready in the same cycle.
- R6: A write to offset F6h stores the low 1, 2 or 4 bytes of `host_wdata` at the write pointer and leaves the write pointer unchanged.
- R7: A write to offset F8h stores data the same way and then advances the write pointer by the step.
- R8: Read data is little-endian: the byte at the pointer is in bits 7:0, the next byte in 15:8, and so on. Byte lanes beyond the mode width read as zero.
- R9: The pointer byte registers are read/write, and a new value is used by the very next command access.
- R10: A rising edge of `rx_base_en` loads the read pointer high byte with 0Ch and leaves the low byte unchanged.
- R11: While `rx_base_en` is high, a read pointer advance whose sum exceeds 3FFFh wraps to 0C00h plus the overshoot.
- R12: A host write to a read pointer byte beats a base load in the same cycle, and a base load beats a pop advance in the same cycle.
- R13: Host writes to the read-only command offsets F0h and F2h change neither pointers nor SRAM. A read of the write-only offset F6h returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_mode | input | 2 | Bus width mode (00 = 8-bit, 01 = 16-bit, 10 = 32-bit) |
| rx_base_en | input | 1 | Receive-region mode bit |
| host_addr | input | 8 | Register offset |
| host_rd | input | 1 | Read strobe, held until `host_ready` |
| host_wr | input | 1 | Write strobe, one cycle |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid while `host_ready` is high |
| host_ready | output | 1 | Access completes at this clock edge |

## Verification
A command read has its data and `host_ready` in the second cycle of the strobe. A pointer register read is valid in the strobe cycle itself. Register writes, pointer steps and base loads show from the cycle after their edge.

The bench drives on the falling edge and samples one time unit after a falling edge. It counts the falling edges before ready appears and checks that count against R5. Each pointer is read back only after the access that changed it has completed, so every comparison falls in the cycle where the value is due.

// File: rtl/hsp_pkg.sv
// Package: shared offsets, bus width codes and width helpers for the host
// SRAM pointer port. Assumes 8-bit register offsets and a 32-bit data bus.
package hsp_pkg;

    typedef enum logic [1:0] {
        BW_8  = 2'b00,
        BW_16 = 2'b01,
        BW_32 = 2'b10,
        BW_X  = 2'b11
    } bus_width_e;

    localparam logic [7:0] OFS_PEEK   = 8'hF0;
    localparam logic [7:0] OFS_POP    = 8'hF2;
    localparam logic [7:0] OFS_RP_LO  = 8'hF4;
    localparam logic [7:0] OFS_RP_HI  = 8'hF5;
    localparam logic [7:0] OFS_PUT    = 8'hF6;
    localparam logic [7:0] OFS_PUSH   = 8'hF8;
    localparam logic [7:0] OFS_WP_LO  = 8'hFA;
    localparam logic [7:0] OFS_WP_HI  = 8'hFB;

    // Pointer step for a bus width mode; code 11 behaves as 8-bit.
    function automatic logic [2:0] width_step(input logic [1:0] m);
        case (m)
            BW_16:   return 3'd2;
            BW_32:   return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

    // Byte lanes active for a bus width mode.
    function automatic logic [3:0] width_lanes(input logic [1:0] m);
        case (m)
            BW_16:   return 4'b0011;
            BW_32:   return 4'b1111;
            default: return 4'b0001;
        endcase
    endfunction

endpackage

// File: rtl/hsp_sram.sv
// Byte-wide synchronous SRAM model with a 4-lane write port and a 4-lane
// registered read port (one cycle read latency). Lane i reaches byte
// address addr+i, modulo the depth. Contents are not reset.
module hsp_sram #(
    parameter int AW    = 10,
    parameter int PW    = 16,
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               we,
    input  logic [LANES-1:0]   we_lanes,
    input  logic [PW-1:0]      waddr,
    input  logic [8*LANES-1:0] wdata,
    input  logic               re,
    input  logic [PW-1:0]      raddr,
    output logic [8*LANES-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    // Store each enabled lane at its consecutive byte address.
    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < LANES; i++) begin
                if (we_lanes[i]) begin
                    mem[AW'(waddr + PW'(i))] <= wdata[8*i +: 8];
                end
            end
        end
    end

    // One registered read lane per byte position.
    for (genvar g = 0; g < LANES; g++) begin : g_rd_lane
        always_ff @(posedge clk) begin
            if (re) begin
                rdata[8*g +: 8] <= mem[AW'(raddr + PW'(g))];
            end
        end
    end

endmodule

// File: rtl/hsp_ptr.sv
// One 16-bit buffer pointer with host byte writes, an optional high-byte
// base load, and a step advance. WRAP_EN selects the variant that wraps
// into [WRAP_BASE, WRAP_END] while wrap_on is high.
// Priority: host byte write > base load > advance.
module hsp_ptr #(
    parameter int              PTR_W     = 16,
    parameter bit              WRAP_EN   = 1'b0,
    parameter logic [PTR_W-1:0] WRAP_BASE = 16'h0C00,
    parameter logic [PTR_W-1:0] WRAP_END  = 16'h3FFF,
    parameter logic [PTR_W-1:0] LOAD_VAL  = 16'h0C00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lo_we,
    input  logic             hi_we,
    input  logic [7:0]       wbyte,
    input  logic             base_ld,
    input  logic             adv,
    input  logic [2:0]       step,
    input  logic             wrap_on,
    output logic [PTR_W-1:0] ptr
);
    localparam int HI_W = PTR_W - 8;

    logic [PTR_W:0]   sum;
    logic [PTR_W-1:0] adv_val;
    logic [PTR_W-1:0] nxt;

    // Sum of pointer and step, one bit wider to see overshoot.
    always_comb sum = {1'b0, ptr} + (PTR_W+1)'(step);

    if (WRAP_EN) begin : g_wrap
        logic [PTR_W:0] wrapped;
        // Fold an overshoot past the region end back to the region base.
        always_comb begin
            wrapped = sum - {1'b0, WRAP_END} - (PTR_W+1)'(1) + {1'b0, WRAP_BASE};
            if (wrap_on && sum > {1'b0, WRAP_END}) begin
                adv_val = wrapped[PTR_W-1:0];
            end else begin
                adv_val = sum[PTR_W-1:0];
            end
        end

        a_r11_stay_in_region: assert property (@(posedge clk) disable iff (!rst_n)
            (adv && wrap_on && !base_ld && !lo_we && !hi_we &&
             ptr >= WRAP_BASE && ptr <= WRAP_END)
            |=> (ptr >= WRAP_BASE && ptr <= WRAP_END));
    end else begin : g_plain
        // Plain modulo advance.
        always_comb adv_val = sum[PTR_W-1:0];
    end

    // Next pointer value by priority.
    always_comb begin
        nxt = ptr;
        if (base_ld) begin
            nxt[PTR_W-1:8] = LOAD_VAL[PTR_W-1:8];
        end else if (adv) begin
            nxt = adv_val;
        end
        if (lo_we) nxt[7:0] = wbyte;
        if (hi_we) nxt[PTR_W-1:8] = HI_W'(wbyte);
    end

    // Pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= '0;
        else        ptr <= nxt;
    end

    a_r4_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !base_ld && !lo_we && !hi_we && !wrap_on)
        |=> ptr == $past(ptr) + PTR_W'($past(step)));

    a_r10_base_high: assert property (@(posedge clk) disable iff (!rst_n)
        (base_ld && !hi_we) |=> ptr[PTR_W-1:8] == LOAD_VAL[PTR_W-1:8]);

    a_r12_host_byte_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hi_we |=> ptr[PTR_W-1:8] == HI_W'($past(wbyte)));

endmodule

// File: rtl/hsp_port.sv
// Top: host register window onto the packet SRAM. Decodes offsets, runs
// the two-cycle command read handshake, steers writes to the SRAM and
// drives the read and write pointers. Assumes the host holds host_rd until
// host_ready and never strobes host_rd and host_wr together.
module hsp_port #(
    parameter int MEM_AW = 10,
    parameter int PTR_W  = 16,
    parameter int DW     = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_mode,
    input  logic          rx_base_en,
    input  logic [7:0]    host_addr,
    input  logic          host_rd,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_ready
);
    import hsp_pkg::*;

    localparam int LANES = DW / 8;

    logic             is_cmd_rd;
    logic             is_cmd_wr;
    logic             rd_valid;
    logic             base_q;
    logic             base_rise;
    logic             pop_done;
    logic [2:0]       step;
    logic [3:0]       lanes;
    logic [DW-1:0]    mem_q;
    logic [DW-1:0]    lane_mask;
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;

    // Offset decode and width helpers.
    always_comb begin
        is_cmd_rd = (host_addr == OFS_PEEK) || (host_addr == OFS_POP);
        is_cmd_wr = (host_addr == OFS_PUT)  || (host_addr == OFS_PUSH);
        step      = width_step(bus_mode);
        lanes     = width_lanes(bus_mode);
        for (int i = 0; i < LANES; i++) lane_mask[8*i +: 8] = {8{lanes[i]}};
    end

    // Command read handshake: data is valid in the cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n)                     rd_valid <= 1'b0;
        else if (rd_valid)              rd_valid <= 1'b0;
        else if (host_rd && is_cmd_rd)  rd_valid <= 1'b1;
    end

    // Edge detector for the receive-region mode bit.
    always_ff @(posedge clk) begin
        if (!rst_n) base_q <= 1'b0;
        else        base_q <= rx_base_en;
    end

    always_comb begin
        base_rise = rx_base_en && !base_q;
        pop_done  = host_rd && (host_addr == OFS_POP) && rd_valid;
    end

    hsp_sram #(.AW(MEM_AW), .PW(PTR_W), .LANES(LANES)) u_sram (
        .clk      (clk),
        .we       (host_wr && is_cmd_wr),
        .we_lanes (lanes),
        .waddr    (wr_ptr),
        .wdata    (host_wdata),
        .re       (host_rd && is_cmd_rd && !rd_valid),
        .raddr    (rd_ptr),
        .rdata    (mem_q)
    );

    hsp_ptr #(.PTR_W(PTR_W), .WRAP_EN(1'b1)) u_rd_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .lo_we   (host_wr && host_addr == OFS_RP_LO),
        .hi_we   (host_wr && host_addr == OFS_RP_HI),
        .wbyte   (host_wdata[7:0]),
        .base_ld (base_rise),
        .adv     (pop_done),
        .step    (step),
        .wrap_on (rx_base_en),
        .ptr     (rd_ptr)
    );

    hsp_ptr #(.PTR_W(PTR_W), .WRAP_EN(1'b0)) u_wr_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .lo_we   (host_wr && host_addr == OFS_WP_LO),
        .hi_we   (host_wr && host_addr == OFS_WP_HI),
        .wbyte   (host_wdata[7:0]),
        .base_ld (1'b0),
        .adv     (host_wr && host_addr == OFS_PUSH),
        .step    (step),
        .wrap_on (1'b0),
        .ptr     (wr_ptr)
    );

    // Read data mux and ready generation.
    always_comb begin
        host_ready = host_wr || (host_rd && (!is_cmd_rd || rd_valid));
        case (host_addr)
            OFS_PEEK, OFS_POP: host_rdata = mem_q & lane_mask;
            OFS_RP_LO:         host_rdata = DW'(rd_ptr[7:0]);
            OFS_RP_HI:         host_rdata = DW'(rd_ptr[PTR_W-1:8]);
            OFS_WP_LO:         host_rdata = DW'(wr_ptr[7:0]);
            OFS_WP_HI:         host_rdata = DW'(wr_ptr[PTR_W-1:8]);
            default:           host_rdata = '0;
        endcase
    end

    a_r5_cmd_ready_late: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ready && host_rd && is_cmd_rd) |-> $past(host_rd && is_cmd_rd));

    a_r3_peek_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_ready && host_addr == OFS_PEEK && !base_rise)
        |=> $stable(rd_ptr));

    a_r13_cmd_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && is_cmd_rd && !base_rise) |=> ($stable(rd_ptr) && $stable(wr_ptr)));

endmodule

// File: tb/hsp_port_test.sv
// Directed bench for hsp_port: one task per scenario, each checking itself.
module hsp_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_mode = 2'b00;
    logic        rx_base_en = 1'b0;
    logic [7:0]  host_addr = 8'h00;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_ready;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    hsp_port uut (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .rx_base_en(rx_base_en),
        .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ready(host_ready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d, output int waits);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1;
        waits = 0;
        while (!host_ready && waits < 10) begin
            @(negedge clk); #1;
            waits++;
        end
        d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic set_rp(input logic [15:0] p);
        do_write(8'hF4, {24'h0, p[7:0]});
        do_write(8'hF5, {24'h0, p[15:8]});
    endtask

    task automatic get_ptr(input logic [7:0] lo_ofs, output logic [15:0] p);
        logic [31:0] d; int w;
        do_read(lo_ofs, d, w); p[7:0] = d[7:0];
        do_read(lo_ofs + 8'd1, d, w); p[15:8] = d[7:0];
    endtask

    task automatic t_reset;
        logic [15:0] p;
        get_ptr(8'hF4, p); check("R1 read ptr reset", 32'(p), 32'h0);
        get_ptr(8'hFA, p); check("R1 write ptr reset", 32'(p), 32'h0);
    endtask

    task automatic t_write_path;
        logic [15:0] p;
        do_write(8'hFA, 32'h00); do_write(8'hFB, 32'h01);
        get_ptr(8'hFA, p); check("R9 write ptr set", 32'(p), 32'h0100);
        bus_mode = 2'b10;
        do_write(8'hF8, 32'h44332211);
        get_ptr(8'hFA, p); check("R7 push step 4 (R2 mode 10)", 32'(p), 32'h0104);
        bus_mode = 2'b01;
        do_write(8'hF8, 32'h9999BBAA);
        get_ptr(8'hFA, p); check("R7 push step 2 (R2 mode 01)", 32'(p), 32'h0106);
        bus_mode = 2'b00;
        do_write(8'hF6, 32'h000000CC);
        get_ptr(8'hFA, p); check("R6 put keeps write ptr", 32'(p), 32'h0106);
        bus_mode = 2'b11;
        do_write(8'hF8, 32'h000000DD);
        get_ptr(8'hFA, p); check("R2 mode 11 steps 1", 32'(p), 32'h0107);
    endtask

    task automatic t_peek_pop;
        logic [31:0] d; logic [15:0] p; int w;
        set_rp(16'h0100);
        bus_mode = 2'b10;
        do_read(8'hF0, d, w);
        check("R3 peek data", d, 32'h44332211);
        check("R5 command read waits one cycle", 32'(w), 32'd1);
        get_ptr(8'hF4, p); check("R3 peek keeps read ptr", 32'(p), 32'h0100);
        do_read(8'hF4, d, w);
        check("R5 register read ready at once", 32'(w), 32'd0);
        do_read(8'hF2, d, w);
        check("R4 pop data 32-bit", d, 32'h44332211);
        get_ptr(8'hF4, p); check("R4 pop step 4", 32'(p), 32'h0104);
        bus_mode = 2'b01;
        do_read(8'hF2, d, w);
        check("R8 16-bit little-endian, upper zero", d, 32'h0000BBAA);
        get_ptr(8'hF4, p); check("R4 pop step 2", 32'(p), 32'h0106);
        bus_mode = 2'b00;
        do_read(8'hF2, d, w);
        check("R6 put overwritten by later push, 8-bit lane", d, 32'h000000DD);
        get_ptr(8'hF4, p); check("R4 pop step 1", 32'(p), 32'h0107);
        set_rp(16'h0105);
        do_read(8'hF0, d, w);
        check("R9 new read ptr used by next command", d, 32'h000000BB);
    endtask

    task automatic t_ignore;
        logic [31:0] d; logic [15:0] p; int w;
        set_rp(16'h0100);
        do_write(8'hF2, 32'h00000055);
        do_write(8'hF0, 32'h00000066);
        get_ptr(8'hF4, p); check("R13 write to read command keeps read ptr", 32'(p), 32'h0100);
        get_ptr(8'hFA, p); check("R13 write to read command keeps write ptr", 32'(p), 32'h0107);
        bus_mode = 2'b00;
        do_read(8'hF0, d, w);
        check("R13 SRAM unchanged", d, 32'h00000011);
        do_read(8'hF6, d, w);
        check("R13 write-only reads zero", d, 32'h0);
        check("R13 write-only read ready at once", 32'(w), 32'd0);
    endtask

    task automatic t_base_load;
        logic [15:0] p;
        set_rp(16'h1234);
        @(negedge clk); rx_base_en = 1'b1;
        get_ptr(8'hF4, p); check("R10 base load high byte", 32'(p), 32'h0C34);
    endtask

    task automatic t_wrap;
        logic [31:0] d; logic [15:0] p; int w;
        set_rp(16'h3FFE);
        bus_mode = 2'b10;
        do_read(8'hF2, d, w);
        get_ptr(8'hF4, p); check("R11 wrap with overshoot", 32'(p), 32'h0C02);
        set_rp(16'h3FFF);
        bus_mode = 2'b00;
        do_read(8'hF2, d, w);
        get_ptr(8'hF4, p); check("R11 wrap to region base", 32'(p), 32'h0C00);
    endtask

    task automatic t_priority;
        logic [15:0] p;
        @(negedge clk); rx_base_en = 1'b0;
        set_rp(16'h2010);
        bus_mode = 2'b00;
        @(negedge clk); host_addr = 8'hF2; host_rd = 1'b1;
        @(negedge clk); rx_base_en = 1'b1;
        @(negedge clk); host_rd = 1'b0;
        get_ptr(8'hF4, p); check("R12 base load beats pop advance", 32'(p), 32'h0C10);
        @(negedge clk); rx_base_en = 1'b0;
        set_rp(16'h2010);
        @(negedge clk);
        host_addr = 8'hF5; host_wdata = 32'h22; host_wr = 1'b1; rx_base_en = 1'b1;
        @(negedge clk); host_wr = 1'b0;
        get_ptr(8'hF4, p); check("R12 host write beats base load", 32'(p), 32'h2210);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_path();
        t_peek_pop();
        t_ignore();
        t_base_load();
        t_wrap();
        t_priority();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule